// File: doc/BRIEF.md
# Phase Lock Detector

This block decides whether a clock loop is phase-aligned. A fast sampling clock watches two slower clock signals, the reference and the loop feedback, and detects their rising edges. For every reference edge the block measures how many sample ticks separate it from the nearest feedback rising edge, on either side. It then compares that distance against a resolution window. The window is set per frequency-range code by parameters given in sample ticks.

A single lock bit is the result. It rises only after a run of consecutive in-window comparisons. It falls on the first out-of-window comparison. It is also held low whenever the loop is not in its normal operating mode, which means powered down, in test mode, or without a reference clock. The control inputs are quasi-static and are sampled on the sampling clock without synchronisers. The two clock inputs pass through synchronisers of equal depth, so their relative distance is kept.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset `lock` is low, and it stays low until in-window comparisons have accumulated.
- R2: At each reference rising edge, the distance is the number of sample ticks to the nearest feedback rising edge before or after it. Edges in the same tick give distance 0. A pair counts as in-window when the distance is at most the selected window.
- R3: The window is chosen by `range_sel`. Code 2'b00 selects WIN_LO (default 8 ticks), 2'b01 selects WIN_MID (default 8), and both 2'b10 and 2'b11 select WIN_HI (default 4).
- R4: `lock` rises in the cycle after the LOCK_RUN-th consecutive in-window comparison (default 4), and not before.
- R5: A single out-of-window comparison drives `lock` low in the next cycle and restarts the run count.
- R6: If no feedback edge is seen across two reference edges, the comparison counts as out-of-window.
- R7: While `pwr_dn_n` is low, all measurement state is cleared and `lock` is low from the next cycle.
- R8: While `test_mode` is high, `lock` is low from the next cycle and the run count is cleared.
- R9: If no reference edge has been seen for REF_IDLE_MAX ticks (default 64), the reference counts as absent and `lock` goes low. Before that limit is reached, `lock` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Feedback clock, asynchronous |
| range_sel | input | 2 | Frequency-range code selecting the window |
| pwr_dn_n | input | 1 | Low powers down and clears the detector |
| test_mode | input | 1 | High marks non-normal (test) operation |
| lock | output | 1 | Phase-lock indication |

## Verification
Two functions can fall in the same cycle. A reference edge and a feedback edge can be detected in one tick, which must measure distance 0 and count as in-window. A comparison result can also arrive in the same cycle that power-down, test mode or reference loss takes effect, and the leaving of normal mode must win. The first case is provoked by a zero-offset stimulus and across the offset sweep. The second is provoked by asserting `pwr_dn_n` low or `test_mode` while comparison results keep arriving. In both cases the bench judges only by `lock` against the level computed from the offset and window.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic [1:0] {
        RANGE_LO  = 2'b00,
        RANGE_MID = 2'b01,
        RANGE_HI  = 2'b10
    } range_e;

    typedef struct packed {
        logic valid;
        logic in_win;
    } pair_res_t;

endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } edge_st_t;

    edge_st_t st_q, st_d;
    logic [STAGES-1:0] sh_next;

    generate
        if (STAGES == 1) begin : g_single
            assign sh_next = din;
        end else begin : g_chain
            assign sh_next = {st_q.sh[STAGES-2:0], din};
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.sh   = sh_next;
        st_d.prev = st_q.sh[STAGES-1];
        if (clear) begin
            st_d = '0;
        end
    end

    assign rise = st_q.sh[STAGES-1] & ~st_q.prev & ~clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lockdet_pair.sv
module lockdet_pair
    import lockdet_pkg::*;
#(
    parameter int AGE_W   = 8,
    parameter int WIN_LO  = 8,
    parameter int WIN_MID = 8,
    parameter int WIN_HI  = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic [1:0] range_sel,
    input  logic      ref_edge,
    input  logic      fb_edge,
    output pair_res_t res
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    typedef struct packed {
        logic [AGE_W-1:0] fb_age;
        logic [AGE_W-1:0] ref_age;
        logic             pending;
        logic [1:0]       miss;
    } pair_st_t;

    localparam pair_st_t ST_INIT = '{fb_age: AGE_MAX, ref_age: AGE_MAX,
                                     pending: 1'b0, miss: 2'd0};

    pair_st_t st_q, st_d;
    logic [AGE_W-1:0] win;
    logic [AGE_W-1:0] early;

    always_comb begin
        case (range_e'(range_sel))
            RANGE_LO:  win = AGE_W'(WIN_LO);
            RANGE_MID: win = AGE_W'(WIN_MID);
            default:   win = AGE_W'(WIN_HI);
        endcase
    end

    assign early = fb_edge ? '0 : st_q.fb_age;

    always_comb begin
        st_d       = st_q;
        res        = '0;
        st_d.fb_age  = fb_edge ? AGE_ONE :
                       ((st_q.fb_age == AGE_MAX) ? AGE_MAX : st_q.fb_age + AGE_ONE);
        st_d.ref_age = (st_q.ref_age == AGE_MAX) ? AGE_MAX : st_q.ref_age + AGE_ONE;
        if (fb_edge) begin
            st_d.miss = 2'd0;
        end
        if (ref_edge) begin
            st_d.ref_age = AGE_ONE;
            st_d.pending = 1'b0;
            if (!fb_edge && st_q.miss != 2'd0) begin
                st_d.miss  = 2'd2;
                res.valid  = 1'b1;
                res.in_win = 1'b0;
            end else begin
                if (!fb_edge) begin
                    st_d.miss = 2'd1;
                end
                if (early <= win) begin
                    res.valid  = 1'b1;
                    res.in_win = 1'b1;
                end else begin
                    st_d.pending = 1'b1;
                end
            end
        end else if (st_q.pending) begin
            if (fb_edge) begin
                res.valid    = 1'b1;
                res.in_win   = (st_q.ref_age <= win);
                st_d.pending = 1'b0;
            end else if (st_q.ref_age > win) begin
                res.valid    = 1'b1;
                res.in_win   = 1'b0;
                st_d.pending = 1'b0;
            end
        end
        if (clear) begin
            st_d = ST_INIT;
            res  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lockdet_qual.sv
module lockdet_qual
    import lockdet_pkg::*;
#(
    parameter int LOCK_RUN     = 4,
    parameter int REF_IDLE_MAX = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      test_mode,
    input  logic      ref_edge,
    input  pair_res_t res,
    output logic      normal,
    output logic      lock
);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int IDLE_W = $clog2(REF_IDLE_MAX + 1);
    localparam logic [RUN_W-1:0]  RUN_TOP  = RUN_W'(LOCK_RUN);
    localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(REF_IDLE_MAX);

    typedef struct packed {
        logic [IDLE_W-1:0] idle;
        logic [RUN_W-1:0]  run;
        logic              lock;
    } qual_st_t;

    qual_st_t st_q, st_d;

    assign normal = ~clear & ~test_mode & (st_q.idle < IDLE_TOP);

    always_comb begin
        st_d      = st_q;
        st_d.idle = ref_edge ? '0 :
                    ((st_q.idle == IDLE_TOP) ? IDLE_TOP : st_q.idle + 1'b1);
        if (!normal) begin
            st_d.run  = '0;
            st_d.lock = 1'b0;
        end else if (res.valid) begin
            if (res.in_win) begin
                st_d.run  = (st_q.run == RUN_TOP) ? RUN_TOP : st_q.run + 1'b1;
                st_d.lock = (st_d.run == RUN_TOP);
            end else begin
                st_d.run  = '0;
                st_d.lock = 1'b0;
            end
        end
        if (clear) begin
            st_d = '0;
        end
    end

    assign lock = st_q.lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import lockdet_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int AGE_W        = 8,
    parameter int WIN_LO       = 8,
    parameter int WIN_MID      = 8,
    parameter int WIN_HI       = 4,
    parameter int LOCK_RUN     = 4,
    parameter int REF_IDLE_MAX = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic [1:0] range_sel,
    input  logic       pwr_dn_n,
    input  logic       test_mode,
    output logic       lock
);
    localparam int N_CLK = 2;

    logic [N_CLK-1:0] raw_w;
    logic [N_CLK-1:0] rise_w;
    logic             clear_w;
    logic             normal_w;
    pair_res_t        res_w;

    assign clear_w = ~pwr_dn_n;
    assign raw_w   = {fb_in, ref_in};

    generate
        for (genvar g = 0; g < N_CLK; g++) begin : g_edge
            lockdet_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (clear_w),
                .din   (raw_w[g]),
                .rise  (rise_w[g])
            );
        end
    endgenerate

    lockdet_pair #(
        .AGE_W   (AGE_W),
        .WIN_LO  (WIN_LO),
        .WIN_MID (WIN_MID),
        .WIN_HI  (WIN_HI)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_w),
        .range_sel (range_sel),
        .ref_edge  (rise_w[0]),
        .fb_edge   (rise_w[1]),
        .res       (res_w)
    );

    lockdet_qual #(
        .LOCK_RUN     (LOCK_RUN),
        .REF_IDLE_MAX (REF_IDLE_MAX)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_w),
        .test_mode (test_mode),
        .ref_edge  (rise_w[0]),
        .res       (res_w),
        .normal    (normal_w),
        .lock      (lock)
    );
endmodule

// File: rtl/pll_lock_detect_chk.sv
module pll_lock_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn_n,
    input logic test_mode,
    input logic normal,
    input logic res_valid,
    input logic res_in,
    input logic lock
);
    a_r7_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> !lock);

    a_r8_test_low: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> !lock);

    a_r5_out_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_in) |=> !lock);

    a_r4_rise_after_in: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(res_valid && res_in && normal));

    a_r9_abnormal_low: assert property (@(posedge clk) disable iff (!rst_n)
        !normal |=> !lock);
endmodule

bind pll_lock_detect pll_lock_detect_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn_n  (pwr_dn_n),
    .test_mode (test_mode),
    .normal    (normal_w),
    .res_valid (res_w.valid),
    .res_in    (res_w.in_win),
    .lock      (lock)
);

// File: tb/pll_lock_detect_tb_top.sv
module pll_lock_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [1:0] range_sel = 2'b00;
    logic       pwr_dn_n = 1'b1;
    logic       test_mode = 1'b0;
    logic       lock;

    int t = 0;
    int dofs = 0;
    bit ref_en = 1'b1;
    bit fb_en = 1'b1;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pll_lock_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .range_sel (range_sel),
        .pwr_dn_n  (pwr_dn_n),
        .test_mode (test_mode),
        .lock      (lock)
    );

    task automatic step();
        @(negedge clk);
        t++;
        ref_in = ref_en && ((t % 20) < 10);
        fb_in  = fb_en && (((t - dofs + 2000) % 20) < 10);
    endtask

    task automatic run_to(input int ph);
        do step(); while ((t % 20) != ph);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: lock=%0b expected %0b (t=%0d)", tag, act, exp, t);
        end
    endtask

    function automatic int win_of(input int r);
        return (r == 0) ? 8 : (r == 1) ? 8 : 4;
    endfunction

    task automatic lock_up(input int r);
        run_to(16);
        pwr_dn_n = 1'b0;
        run_to(17);
        pwr_dn_n  = 1'b1;
        dofs      = 0;
        range_sel = 2'(r);
        repeat (6) run_to(15);
        chk("R4 relock", lock, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: lock=%0b expected end of run", lock);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        chk("R1 in reset", lock, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", lock, 1'b0);

        // R4: exact count of in-window pairs before lock
        run_to(16);
        pwr_dn_n = 1'b0;
        run_to(17);
        pwr_dn_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            run_to(15);
            chk($sformatf("R4 pair %0d", k), lock, (k >= 4) ? 1'b1 : 1'b0);
        end

        // R2/R3: sweep of range codes and offsets
        for (int r = 0; r < 4; r++) begin
            for (int d = -9; d <= 9; d++) begin
                run_to(19);
                range_sel = 2'(r);
                dofs      = d;
                repeat (8) run_to(15);
                chk($sformatf("R2 R3 range=%0d ofs=%0d", r, d), lock,
                    ((d < 0 ? -d : d) <= win_of(r)) ? 1'b1 : 1'b0);
            end
        end

        // R5: one out-of-window pair drops lock, run restarts
        lock_up(2);
        run_to(19);
        dofs = 9;
        run_to(15);
        chk("R5 single out pair", lock, 1'b0);
        run_to(19);
        dofs = 0;
        repeat (3) run_to(15);
        chk("R5 run restarted", lock, 1'b0);
        run_to(15);
        chk("R4 fourth pair", lock, 1'b1);

        // R6: feedback stops
        run_to(19);
        fb_en = 1'b0;
        repeat (2) run_to(15);
        chk("R6 no feedback", lock, 1'b0);
        fb_en = 1'b1;

        // R7: power-down
        lock_up(0);
        pwr_dn_n = 1'b0;
        step();
        chk("R7 powered down", lock, 1'b0);
        repeat (2) run_to(15);
        chk("R7 stays low", lock, 1'b0);
        pwr_dn_n = 1'b1;

        // R8: test mode
        lock_up(1);
        test_mode = 1'b1;
        step();
        chk("R8 test mode", lock, 1'b0);
        repeat (2) run_to(15);
        chk("R8 stays low", lock, 1'b0);
        test_mode = 1'b0;

        // R9: reference absent
        lock_up(0);
        run_to(19);
        ref_en = 1'b0;
        repeat (30) step();
        chk("R9 before idle limit", lock, 1'b1);
        repeat (40) step();
        chk("R9 reference lost", lock, 1'b0);
        ref_en = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule